// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block drives the active-low system reset of a chip from a set of digital rail-good flags, an active-low manual reset request and a watchdog strobe. The reset is held low while any rail flag reports a bad supply or while the manual request is low. It is released only after a fixed hold period has run with every condition clean. Any new fault during that period restarts the count.

A built-in watchdog watches the strobe. Each rising or falling edge clears its counter. If the strobe stays at one level for longer than the timeout, the watchdog forces a fresh reset pulse. That pulse uses the same hold period as any other cause. After every reset, the first strobe edge is given a much longer startup window, and the normal timeout applies from then on. A separate enable input stands for a strobe that is left unconnected. While it is low, the watchdog is inert.

All timing comes from the clock divided by a tick prescaler. The hold period and both watchdog windows are parameters counted in ticks. The defaults are a 1 ms tick at 50 MHz, a 140-tick hold, a 1600-tick timeout and a 54000-tick startup window.

Top module: `supervisor_reset_seq`

## Requirements
- R1: While any bit of `rail_ok` is 0, `sys_rst_n` is 0 from the clock edge that first samples the bad flag onward.
- R2: `mr_n` passes through a two-stage synchronizer. A low level drives `sys_rst_n` to 0 on the third clock edge after it is applied.
- R3: `sys_rst_n` returns to 1 on exactly the RST_TICKS*TICK_DIV-th clock edge that samples all conditions clean. Any fault seen earlier restarts this count from zero.
- R4: During `rst` and after it, `sys_rst_n` is 0. It follows the R3 release sequence, with the synchronizer delay on `mr_n` added.
- R5: A rising edge and a falling edge of `wd_strobe` each clear the watchdog. A strobe that changes level at intervals shorter than WD_TICKS*TICK_DIV cycles never causes a reset.
- R6: With the strobe idle, the watchdog forces `sys_rst_n` to 0 one cycle after its window of ticks has elapsed since it was last cleared. That reset is then held for the R3 period.
- R7: After each reset, the first strobe edge is allowed WD_START_TICKS ticks. After that first edge, each later edge is held to WD_TICKS ticks.
- R8: While `wd_en` is 0, the watchdog never causes a reset and is returned to its startup state.
- R9: A reset from any cause, including a rail fault or a watchdog bite, clears the watchdog and restores the startup window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| rail_ok | input | N_RAILS | One flag per monitored rail, 1 = above threshold |
| mr_n | input | 1 | Manual reset request, active low, asynchronous |
| wd_strobe | input | 1 | Watchdog strobe, asynchronous |
| wd_en | input | 1 | 1 = watchdog active, 0 = strobe treated as unconnected |
| sys_rst_n | output | 1 | Registered active-low system reset |

## Verification
The hardest state to reach is a strobe edge that arrives after the normal timeout has already passed but before the startup window ends, because this must happen straight after a release. The stimulus gets there by waiting a fixed number of cycles after each observed release and then toggling the strobe. It then drives randomly spaced edges that stay just under the normal timeout, and finally lets the strobe idle so that the shorter limit can be seen to apply. A rail dip is then placed after the watchdog has left its startup state. This shows that the following release again grants the long window.

// File: rtl/supervisor_pkg.sv
package supervisor_pkg;

  typedef enum logic {
    WD_STARTUP = 1'b0,
    WD_NORMAL  = 1'b1
  } wd_phase_t;

  function automatic int cnt_width(input int limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int DIV = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = supervisor_pkg::cnt_width(DIV);

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || clr || tick) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  // R3: the divider never runs past its terminal count
  p_div_range_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DIV - 1));
endmodule

// File: rtl/level_sync.sv
module level_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/release_timer.sv
module release_timer #(
  parameter int RST_TICKS = 140
) (
  input  logic clk,
  input  logic rst,
  input  logic fault,
  input  logic tick,
  output logic hold
);
  localparam int TW = supervisor_pkg::cnt_width(RST_TICKS + 1);

  logic [TW-1:0] tcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= 1'b1;
      tcnt <= '0;
    end else if (fault) begin
      hold <= 1'b1;
      tcnt <= '0;
    end else if (hold && tick) begin
      if (tcnt == TW'(RST_TICKS - 1)) begin
        hold <= 1'b0;
        tcnt <= '0;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  // R1/R2: any fault sets the hold on the next edge
  p_fault_holds_r1: assert property (@(posedge clk) disable iff (rst)
    fault |=> hold);
  // R3: release only at the last tick of a clean count
  p_release_after_count_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(hold) |-> ($past(tcnt) == TW'(RST_TICKS - 1) && !$past(fault)));
endmodule

// File: rtl/watchdog_core.sv
module watchdog_core #(
  parameter int WD_TICKS       = 1600,
  parameter int WD_START_TICKS = 54000
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  input  logic wd_en,
  input  logic strobe_lvl,
  input  logic tick,
  output logic pre_clr,
  output logic bite
);
  import supervisor_pkg::*;

  localparam int MAXT = (WD_START_TICKS > WD_TICKS) ? WD_START_TICKS : WD_TICKS;
  localparam int WCW  = cnt_width(MAXT + 1);

  logic           prev_lvl;
  logic           strobe_edge;
  logic [WCW-1:0] wcnt;
  logic [WCW-1:0] lim;
  wd_phase_t      phase;

  always_ff @(posedge clk) begin
    if (rst) prev_lvl <= 1'b0;
    else     prev_lvl <= strobe_lvl;
  end

  assign strobe_edge = strobe_lvl ^ prev_lvl;
  assign pre_clr     = hold_i || !wd_en || strobe_edge;
  assign lim = (phase == WD_STARTUP) ? WCW'(WD_START_TICKS - 1) : WCW'(WD_TICKS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt  <= '0;
      phase <= WD_STARTUP;
      bite  <= 1'b0;
    end else begin
      bite <= 1'b0;
      if (hold_i || !wd_en) begin
        wcnt  <= '0;
        phase <= WD_STARTUP;
      end else if (strobe_edge) begin
        wcnt  <= '0;
        phase <= WD_NORMAL;
      end else if (tick) begin
        if (wcnt == lim) begin
          wcnt <= '0;
          bite <= 1'b1;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
      end
    end
  end

  // R5: either strobe edge clears the count and ends the startup window
  p_edge_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (strobe_edge && !hold_i && wd_en) |=> (wcnt == '0 && phase == WD_NORMAL));
  // R9: a reset restores the startup state
  p_reset_clears_r9: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> (wcnt == '0 && phase == WD_STARTUP && !bite));
  // R8: disabled watchdog never bites
  p_disabled_no_bite_r8: assert property (@(posedge clk) disable iff (rst)
    !wd_en |=> !bite);
  // R6: a bite is a single-cycle pulse
  p_bite_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    bite |=> !bite);
endmodule

// File: rtl/supervisor_reset_seq.sv
module supervisor_reset_seq #(
  parameter int N_RAILS        = 4,
  parameter int TICK_DIV       = 50000,
  parameter int RST_TICKS      = 140,
  parameter int WD_TICKS       = 1600,
  parameter int WD_START_TICKS = 54000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_RAILS-1:0] rail_ok,
  input  logic               mr_n,
  input  logic               wd_strobe,
  input  logic               wd_en,
  output logic               sys_rst_n
);
  logic [1:0] sync_q;
  logic       mr_q, strobe_q;
  logic       fault, hold, bite;
  logic       rel_tick, wd_tick, wd_clr;

  level_sync #(.W(2), .RST_VAL(2'b00)) u_sync (
    .clk(clk), .rst(rst), .d({wd_strobe, mr_n}), .q(sync_q)
  );
  assign mr_q     = sync_q[0];
  assign strobe_q = sync_q[1];

  assign fault = !(&rail_ok) || !mr_q || bite;

  tick_prescaler #(.DIV(TICK_DIV)) u_rel_div (
    .clk(clk), .rst(rst), .clr(fault), .tick(rel_tick)
  );

  release_timer #(.RST_TICKS(RST_TICKS)) u_release (
    .clk(clk), .rst(rst), .fault(fault), .tick(rel_tick), .hold(hold)
  );

  tick_prescaler #(.DIV(TICK_DIV)) u_wd_div (
    .clk(clk), .rst(rst), .clr(wd_clr), .tick(wd_tick)
  );

  watchdog_core #(.WD_TICKS(WD_TICKS), .WD_START_TICKS(WD_START_TICKS)) u_wd (
    .clk(clk), .rst(rst), .hold_i(hold), .wd_en(wd_en), .strobe_lvl(strobe_q),
    .tick(wd_tick), .pre_clr(wd_clr), .bite(bite)
  );

  assign sys_rst_n = !hold;

  // R1: a bad rail forces reset on the next edge
  p_rail_forces_reset_r1: assert property (@(posedge clk) disable iff (rst)
    !(&rail_ok) |=> !sys_rst_n);
  // R2: synchronized manual request forces reset
  p_manual_forces_reset_r2: assert property (@(posedge clk) disable iff (rst)
    !mr_q |=> !sys_rst_n);
  // R6: a bite forces reset
  p_bite_forces_reset_r6: assert property (@(posedge clk) disable iff (rst)
    bite |=> !sys_rst_n);
endmodule

// File: tb/supervisor_reset_seq_tb.sv
module supervisor_reset_seq_tb;
  localparam int N  = 4;
  localparam int D  = 4;
  localparam int RT = 5;
  localparam int WT = 6;
  localparam int ST = 20;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] rail_ok;
  logic         mr_n, wd_strobe, wd_en;
  logic         sys_rst_n;
  int           checks = 0;
  int           errors = 0;

  always #10 clk = ~clk;

  supervisor_reset_seq #(.N_RAILS(N), .TICK_DIV(D), .RST_TICKS(RT),
                         .WD_TICKS(WT), .WD_START_TICKS(ST)) u_dut (
    .clk(clk), .rst(rst), .rail_ok(rail_ok), .mr_n(mr_n),
    .wd_strobe(wd_strobe), .wd_en(wd_en), .sys_rst_n(sys_rst_n)
  );

  function automatic int hold_len();
    return RT * D;
  endfunction

  function automatic int bite_len(input bit startup);
    return (startup ? ST : WT) * D;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic exp);
    checks++;
    if (sys_rst_n !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, sys_rst_n, exp);
    end
  endtask

  task automatic stay(input string req, input int n, input logic exp);
    for (int i = 0; i < n; i++) begin
      step(1);
      chk(req, "level held", exp);
    end
  endtask

  task automatic release_seq(input string req);
    step(hold_len() - 1);
    chk(req, "still held one edge before release", 1'b0);
    step(1);
    chk(req, "released", 1'b1);
  endtask

  task automatic toggle();
    wd_strobe = ~wd_strobe;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; rail_ok = '1; mr_n = 1'b1; wd_strobe = 1'b0; wd_en = 1'b0;
    step(1);
    chk("R4", "asserted in reset", 1'b0);
    step(4);
    rst = 1'b0;
    step(hold_len() + 1);
    chk("R4", "held through power-on count", 1'b0);
    step(1);
    chk("R4", "power-on release", 1'b1);

    // R1: random rail dips
    for (int it = 0; it < 6; it++) begin
      int idx = $urandom_range(N - 1, 0);
      int k   = $urandom_range(8, 1);
      rail_ok[idx] = 1'b0;
      step(1);
      chk("R1", "rail bad", 1'b0);
      stay("R1", k, 1'b0);
      rail_ok[idx] = 1'b1;
      release_seq("R3");
    end

    // R3: fault during the count restarts it
    for (int it = 0; it < 4; it++) begin
      int j = $urandom_range(hold_len() - 2, 1);
      rail_ok[0] = 1'b0;
      step(1);
      rail_ok[0] = 1'b1;
      stay("R3", j, 1'b0);
      rail_ok[N-1] = 1'b0;
      step(1);
      rail_ok[N-1] = 1'b1;
      release_seq("R3");
    end

    // R2: manual reset through the synchronizer
    mr_n = 1'b0;
    step(2);
    chk("R2", "not yet through sync", 1'b1);
    step(1);
    chk("R2", "manual reset asserted", 1'b0);
    stay("R2", $urandom_range(6, 1), 1'b0);
    mr_n = 1'b1;
    step(hold_len() + 1);
    chk("R2", "held after manual release", 1'b0);
    step(1);
    chk("R2", "released after manual", 1'b1);

    // R7/R6: startup window, then bite and its hold period
    wd_en = 1'b1;
    step(bite_len(1));
    chk("R7", "alive through startup window", 1'b1);
    step(1);
    chk("R6", "startup bite", 1'b0);
    release_seq("R6");

    // R7: first edge late in the startup window, then R5 random feeding
    stay("R7", bite_len(1) - 5, 1'b1);
    toggle();
    for (int it = 0; it < 10; it++) begin
      int k = $urandom_range(bite_len(0) - 1, 2);
      stay("R5", k, 1'b1);
      toggle();
    end
    step(3 + bite_len(0));
    chk("R7", "normal window in force", 1'b1);
    step(1);
    chk("R6", "idle strobe bite", 1'b0);
    release_seq("R6");

    // R9: rail fault after normal mode restores the startup window
    toggle();
    step(5);
    rail_ok[1] = 1'b0;
    step(1);
    chk("R9", "rail dip in normal mode", 1'b0);
    rail_ok[1] = 1'b1;
    release_seq("R9");
    step(bite_len(1));
    chk("R9", "startup window restored", 1'b1);
    step(1);
    chk("R9", "bite at startup limit", 1'b0);
    release_seq("R9");

    // R8: disabled watchdog is inert and re-arms in startup
    wd_en = 1'b0;
    stay("R8", bite_len(1) + bite_len(0) + 10, 1'b1);
    wd_en = 1'b1;
    step(bite_len(1));
    chk("R8", "re-enabled gets startup window", 1'b1);
    step(1);
    chk("R8", "re-enabled bite", 1'b0);
    release_seq("R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule